// File: doc/BRIEF.md
# SPI Flash Page-Program Sequencer

This block writes one 256-byte page of a serial NOR flash through an SPI master port (mode 0, MSB first). A requester first fills the local page buffer through a byte write port. It then raises a request carrying a page number and holds it until the block either turns busy or returns a deferred pulse. The block enables writing and confirms the write-enable latch by status polling. It then sends the program command with the page address and streams the buffer. After that it polls the write-in-progress bit on a timer and finishes with a write-disable command.

Two interlock inputs stand in for the rest of the flash controller. An active erase makes a request bounce at once with a deferred pulse, so the requester can try again later. An active read holds a request back until the read ends. The buffer is released as soon as the data phase ends, while the flash is still busy with its internal program cycle, so the next page can be loaded early.

Top module: `nor_page_prog`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0, busy, done and deferred are 0, and buf_free is 1.
- R2: A request seen while idle with erase_busy high produces a one-cycle deferred pulse on the next cycle. Busy stays 0 and no chip-select frame is sent.
- R3: A request seen while read_busy is high (and erase_busy is low) is held off: busy stays 0 and chip select stays high until read_busy falls. The request then starts.
- R4: Each program run starts with a one-byte frame carrying 0x06. It is followed by two-byte status frames (0x05 then one dummy byte), repeated until the byte received in the second position has bit 1 set.
- R5: Chip select stays high for at least CS_GAP clock cycles before every frame.
- R6: The program frame carries 0x02, then a 24-bit address equal to page*256 sent most significant byte first, then buffer bytes 0 to 255 in increasing order. This is 260 bytes in total. SCK idles low and MOSI is sampled on its rising edge.
- R7: buf_free falls when a request is accepted and rises when the program frame ends, before done. Buffer writes made while buf_free is 0 are ignored.
- R8: After the program frame, two-byte status frames (0x05 plus a dummy byte) repeat until the received byte has bit 0 clear. The chip-select high time before each of these frames is at least POLL_SHORT cycles. It is at least POLL_LONG cycles when erase_busy was high as the wait began.
- R9: Once write-in-progress reads 0, a one-byte frame carrying 0x04 is sent. Then done pulses for one cycle and busy falls in the same cycle.
- R10: A request raised while busy is not taken until the current run has sent its 0x04 frame and signalled done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Program request, held until busy rises or deferred pulses |
| req_page | input | PAGE_W | Page number to program |
| erase_busy | input | 1 | A sector erase is running |
| read_busy | input | 1 | A page read is running |
| buf_we | input | 1 | Page buffer write strobe |
| buf_addr | input | 8 | Page buffer byte address |
| buf_wdata | input | 8 | Page buffer write data |
| busy | output | 1 | A program run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| deferred | output | 1 | One-cycle pulse: request refused because an erase is running |
| buf_free | output | 1 | Page buffer may be written |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The assertions assume that the requester holds req until it sees busy or deferred. They also assume that it writes the buffer only through the port and that the flash eventually sets its write-enable latch and clears write-in-progress. The bench models a flash that keeps the latch clear for a chosen number of status reads and reports write-in-progress for a chosen number of polls. It drives erase_busy only while idle or after the data phase, never in the cycle a request is accepted. It raises and holds req exactly as the handshake asks, so every run ends within a bounded number of polls.

// File: rtl/nor_page_prog.sv
module nor_page_prog #(
  parameter int PAGE_W     = 16,
  parameter int SCK_HALF   = 2,
  parameter int CS_GAP     = 6,
  parameter int POLL_SHORT = 20,
  parameter int POLL_LONG  = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [PAGE_W-1:0] req_page,
  input  logic              erase_busy,
  input  logic              read_busy,
  input  logic              buf_we,
  input  logic [7:0]        buf_addr,
  input  logic [7:0]        buf_wdata,
  output logic              busy,
  output logic              done,
  output logic              deferred,
  output logic              buf_free,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int PAGE_BYTES = 256;
  localparam int PP_LEN     = PAGE_BYTES + 4;
  localparam int IDX_W      = $clog2(PP_LEN + 1);
  localparam int TMR_MAX    = (POLL_LONG > POLL_SHORT) ? POLL_LONG : POLL_SHORT;
  localparam int TMR_W      = $clog2(TMR_MAX + 1);
  localparam int DIV_W      = $clog2(SCK_HALF + 1);
  localparam int GAP_W      = $clog2(CS_GAP + 1);

  typedef enum logic [2:0] {S_IDLE, S_GAP, S_WREN, S_SR1, S_PROG, S_WAIT, S_SR2, S_WRDI} st_t;
  st_t st, nxt;

  logic [7:0]        mem [PAGE_BYTES];
  logic [PAGE_W-1:0] page_q;
  logic [IDX_W-1:0]  idx, nidx, flen, moff;
  logic [2:0]        bitc;
  logic [DIV_W-1:0]  div;
  logic [GAP_W-1:0]  gcnt;
  logic [TMR_W-1:0]  tmr;
  logic [7:0]        sh, rx, tx_nxt, first;
  logic [23:0]       addr;

  assign busy     = (st != S_IDLE);
  assign spi_mosi = sh[7];
  assign addr     = 24'({page_q, 8'h00});
  assign nidx     = idx + 1'b1;
  assign moff     = nidx - IDX_W'(4);
  assign first    = (nxt == S_WREN) ? 8'h06 : (nxt == S_WRDI) ? 8'h04 :
                    (nxt == S_PROG) ? 8'h02 : 8'h05;
  assign flen     = (st == S_PROG) ? IDX_W'(PP_LEN) :
                    (st == S_SR1 || st == S_SR2) ? IDX_W'(2) : IDX_W'(1);

  always_comb begin
    tx_nxt = 8'h00;
    if (st == S_PROG) begin
      case (nidx)
        IDX_W'(1): tx_nxt = addr[23:16];
        IDX_W'(2): tx_nxt = addr[15:8];
        IDX_W'(3): tx_nxt = addr[7:0];
        default:   tx_nxt = mem[moff[7:0]];
      endcase
    end
  end

  always_ff @(posedge clk)
    if (buf_we && buf_free) mem[buf_addr] <= buf_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; nxt <= S_IDLE;
      spi_cs_n <= 1'b1; spi_sck <= 1'b0;
      done <= 1'b0; deferred <= 1'b0; buf_free <= 1'b1;
      page_q <= '0; idx <= '0; bitc <= '0; div <= '0;
      gcnt <= '0; tmr <= '0; sh <= '0; rx <= '0;
    end else begin
      done <= 1'b0;
      deferred <= 1'b0;
      case (st)
        S_IDLE:
          if (req) begin
            if (erase_busy) deferred <= 1'b1;
            else if (!read_busy) begin
              page_q <= req_page; buf_free <= 1'b0;
              st <= S_GAP; nxt <= S_WREN; gcnt <= GAP_W'(CS_GAP - 1);
            end
          end
        S_GAP:
          if (gcnt == '0) begin
            st <= nxt; spi_cs_n <= 1'b0;
            idx <= '0; bitc <= '0; div <= '0; sh <= first;
          end else gcnt <= gcnt - 1'b1;
        S_WAIT:
          if (tmr == '0) begin
            st <= S_GAP; nxt <= S_SR2; gcnt <= GAP_W'(CS_GAP - 1);
          end else tmr <= tmr - 1'b1;
        default:
          if (div == DIV_W'(SCK_HALF - 1)) begin
            div <= '0;
            spi_sck <= ~spi_sck;
            if (!spi_sck) rx <= {rx[6:0], spi_miso};
            else if (bitc != 3'd7) begin
              sh <= {sh[6:0], 1'b0}; bitc <= bitc + 1'b1;
            end else begin
              bitc <= '0; idx <= nidx; sh <= tx_nxt;
              if (nidx == flen) begin
                spi_cs_n <= 1'b1;
                gcnt <= GAP_W'(CS_GAP - 1);
                case (st)
                  S_WREN: begin st <= S_GAP; nxt <= S_SR1; end
                  S_SR1:  begin st <= S_GAP; nxt <= rx[1] ? S_PROG : S_SR1; end
                  S_PROG: begin
                    buf_free <= 1'b1; st <= S_WAIT;
                    tmr <= erase_busy ? TMR_W'(POLL_LONG) : TMR_W'(POLL_SHORT);
                  end
                  S_SR2:
                    if (rx[0]) begin
                      st <= S_WAIT;
                      tmr <= erase_busy ? TMR_W'(POLL_LONG) : TMR_W'(POLL_SHORT);
                    end else begin st <= S_GAP; nxt <= S_WRDI; end
                  default: begin st <= S_IDLE; done <= 1'b1; end
                endcase
              end
            end
          end else div <= div + 1'b1;
      endcase
    end
  end

  logic [7:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hi_cnt <= '0;
    else if (!spi_cs_n) hi_cnt <= '0;
    else if (hi_cnt != 8'hFF) hi_cnt <= hi_cnt + 1'b1;

  a_r5_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> hi_cnt >= 8'(CS_GAP));
  a_r6_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
  a_r2_defer_idle: assert property (@(posedge clk) disable iff (!rst_n)
    deferred |-> !busy && spi_cs_n);
  a_r9_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && buf_free && spi_cs_n);
  a_r9_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r7_free_only_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_free) |-> busy && $rose(spi_cs_n));
endmodule

// File: tb/nor_page_prog_tb.sv
module nor_page_prog_tb;
  localparam int CS_GAP = 6, P_SHORT = 20, P_LONG = 100;

  logic clk = 0, rst_n = 0;
  logic req = 0, erase_busy = 0, read_busy = 0, buf_we = 0;
  logic [15:0] req_page = '0;
  logic [7:0] buf_addr = '0, buf_wdata = '0;
  logic busy, done, deferred, buf_free, spi_cs_n, spi_sck, spi_mosi, spi_miso;

  always #5 clk = ~clk;

  nor_page_prog #(.PAGE_W(16), .SCK_HALF(2), .CS_GAP(CS_GAP),
                  .POLL_SHORT(P_SHORT), .POLL_LONG(P_LONG)) u_dut (
    .clk, .rst_n, .req, .req_page, .erase_busy, .read_busy,
    .buf_we, .buf_addr, .buf_wdata, .busy, .done, .deferred, .buf_free,
    .spi_cs_n, .spi_sck, .spi_mosi, .spi_miso);

  int checks = 0, fails = 0, cyc = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  // flash model and frame log
  bit armed = 0;
  int nfr = 0, nb = 0, hi = 0, wel_lag = 0, wip_polls = 1, welcnt = 0, wipcnt = 0, sck_bad = 0;
  logic [7:0] fop [64];
  int flen_l [64], fgap [64];
  logic [7:0] pbytes [260];
  logic [7:0] sr = 0, cur = 0;
  logic [2:0] bc = 0;
  logic wel = 0, wip = 0;
  wire [7:0] stat = {6'b0, wel, wip};
  assign spi_miso = (cur == 8'h05 && nb == 1) ? stat[3'd7 - bc] : 1'b0;

  always @(posedge clk) begin cyc++; if (spi_cs_n) hi++; end
  always @(negedge spi_cs_n) if (armed) begin
    if (spi_sck) sck_bad++;
    if (nfr < 64) fgap[nfr] = hi;
    hi = 0; nb = 0; bc = 0; cur = 0;
  end
  always @(posedge spi_sck) if (armed) begin
    sr = {sr[6:0], spi_mosi};
    bc = bc + 3'd1;
    if (bc == 3'd0) begin
      if (nb == 0) cur = sr;
      if (cur == 8'h02 && nb < 260) pbytes[nb] = sr;
      nb++;
    end
  end
  always @(posedge spi_cs_n) if (armed) begin
    if (spi_sck) sck_bad++;
    if (nfr < 64) begin fop[nfr] = cur; flen_l[nfr] = nb; end
    nfr++;
    case (cur)
      8'h06: begin wel = (wel_lag == 0); welcnt = wel_lag; end
      8'h02: begin wel = 0; wip = 1; wipcnt = wip_polls; end
      8'h04: wel = 0;
      8'h05:
        if (wip) begin wipcnt--; if (wipcnt == 0) wip = 0; end
        else if (!wel && welcnt > 0) begin welcnt--; if (welcnt == 0) wel = 1; end
      default: ;
    endcase
    cur = 0;
  end

  always @(posedge clk) if (cyc == 190000) begin
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  function automatic logic [7:0] pat(input int i, input logic [15:0] pg);
    return 8'((i * 7) + pg[7:0] + 3);
  endfunction

  task automatic fill(input logic [15:0] pg);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk); buf_we = 1; buf_addr = 8'(i); buf_wdata = pat(i, pg);
    end
    @(negedge clk); buf_we = 0;
  endtask

  task automatic wait_done(output bit free_first);
    int t = 0;
    free_first = 0;
    while (!done && t < 40000) begin
      @(negedge clk); t++;
      if (buf_free && !done && busy) free_first = 1;
    end
  endtask

  task automatic check_run(input logic [15:0] pg, input logic [15:0] datpg, input int p_after);
    int exp_n = 5 + wel_lag + wip_polls;
    int sr2 = wel_lag + 3;
    int mingap = 1000;
    chk(nfr == exp_n, "R4 R8 frame count", nfr, exp_n);
    chk(fop[0] == 8'h06 && flen_l[0] == 1, "R4 write-enable frame", fop[0], 6);
    for (int j = 1; j <= wel_lag + 1; j++)
      chk(fop[j] == 8'h05 && flen_l[j] == 2, "R4 latch poll frame", fop[j], 5);
    chk(fop[wel_lag + 2] == 8'h02 && flen_l[wel_lag + 2] == 260, "R6 program frame length",
        flen_l[wel_lag + 2], 260);
    chk({pbytes[1], pbytes[2], pbytes[3]} == {pg, 8'h00}, "R6 address bytes",
        int'({pbytes[1], pbytes[2], pbytes[3]}), int'({pg, 8'h00}));
    for (int i = 0; i < 256; i++)
      if (pbytes[i + 4] != pat(i, datpg)) begin
        chk(0, "R6 data byte", int'(pbytes[i + 4]), int'(pat(i, datpg))); break;
      end
    chk(1, "R6 data stream", 0, 0);
    for (int j = sr2; j < sr2 + wip_polls + 1; j++) begin
      chk(fop[j] == 8'h05 && flen_l[j] == 2, "R8 progress poll frame", fop[j], 5);
      if (j > sr2)
        chk(fgap[j] >= p_after && fgap[j] <= p_after + CS_GAP + 4, "R8 poll interval",
            fgap[j], p_after);
    end
    chk(fop[exp_n - 1] == 8'h04 && flen_l[exp_n - 1] == 1, "R9 write-disable frame",
        fop[exp_n - 1], 4);
    for (int j = 0; j < exp_n && j < 64; j++) if (fgap[j] < mingap) mingap = fgap[j];
    chk(mingap >= CS_GAP, "R5 chip-select high time", mingap, CS_GAP);
    chk(sck_bad == 0, "R6 sck low at chip-select edges", sck_bad, 0);
  endtask

  task automatic t_reset;
    chk(spi_cs_n && !spi_sck && !busy && !done && !deferred && buf_free, "R1 reset state",
        int'({spi_cs_n, spi_sck, busy, done, deferred, buf_free}), 6'b100001);
  endtask

  task automatic t_defer;
    nfr = 0;
    @(negedge clk); erase_busy = 1; req = 1; req_page = 16'h0033;
    @(negedge clk);
    chk(deferred == 1, "R2 deferred pulse", deferred, 1);
    chk(busy == 0, "R2 no start", busy, 0);
    req = 0;
    @(negedge clk);
    chk(deferred == 0, "R2 deferred one cycle", deferred, 0);
    erase_busy = 0;
    repeat (30) @(negedge clk);
    chk(nfr == 0 && !busy, "R2 no frame sent", nfr, 0);
  endtask

  task automatic t_prog(input logic [15:0] pg, input int wl, input int wp,
                        input bit erase_mid, input int read_hold);
    bit ff;
    fill(pg);
    wel_lag = wl; wip_polls = wp; nfr = 0; sck_bad = 0;
    @(negedge clk); read_busy = (read_hold > 0); req = 1; req_page = pg;
    if (read_hold > 0) begin
      repeat (read_hold) @(negedge clk);
      chk(!busy && nfr == 0 && spi_cs_n, "R3 held off by read", int'(busy), 0);
      read_busy = 0;
    end
    while (!busy) @(negedge clk);
    req = 0;
    chk(!buf_free, "R7 buffer taken", buf_free, 0);
    buf_we = 1; buf_addr = 8'd0; buf_wdata = 8'hEE;
    @(negedge clk); buf_we = 0;
    if (erase_mid) begin
      while (!buf_free) @(negedge clk);
      erase_busy = 1;
    end
    wait_done(ff);
    chk(done == 1, "R9 done pulse", done, 1);
    chk(ff, "R7 buffer free before done", int'(ff), 1);
    @(negedge clk);
    chk(!busy && !done, "R9 idle after done", int'({busy, done}), 0);
    erase_busy = 0;
    check_run(pg, pg, erase_mid ? P_LONG : P_SHORT);
  endtask

  task automatic t_back2back;
    bit ff;
    fill(16'h0005);
    wel_lag = 0; wip_polls = 2; nfr = 0; sck_bad = 0;
    @(negedge clk); req = 1; req_page = 16'h0005;
    while (!busy) @(negedge clk);
    req_page = 16'hFFFF;
    wait_done(ff);
    chk(nfr == 7 && fop[6] == 8'h04, "R10 first run complete before second", nfr, 7);
    check_run(16'h0005, 16'h0005, P_SHORT);
    nfr = 0;
    while (!busy) @(negedge clk);
    req = 0;
    wait_done(ff);
    chk(done == 1, "R10 second run done", done, 1);
    check_run(16'hFFFF, 16'h0005, P_SHORT);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; armed = 1;
    @(negedge clk);
    t_reset();
    t_defer();
    t_prog(16'h0012, 0, 1, 0, 0);
    t_prog(16'hABCD, 3, 3, 0, 30);
    t_prog(16'h0100, 1, 3, 1, 0);
    t_back2back();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule